// File: doc/BRIEF.md
# Flash Command Controller with Sticky Status

This block drives a small word-addressed storage array that behaves like flash. Software writes an address and a data word into two 16-bit registers. It then writes a command code into an 8-bit command register. The controller starts a timed operation and stays busy for a fixed number of clock cycles. When the time is up, the controller performs the array access. Storage bits behave as in flash: an erase sets every bit of a page to one, and a write can only pull bits to zero.

A read-only status register reports four things: busy, command complete, command failed and interrupt pending. The complete, failed and interrupt-pending bits are sticky and clear when software reads the status register. A mode register holds the interrupt enable. The interrupt output is a level that follows the pending bit.

Every duration is a cycle-count parameter. By default an erase-then-write lasts a thousand times longer than a plain write.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` are 0 status, 1 mode, 2 command, 3 data and 4 address. After reset every register reads zero and `irq` is low. The mode register keeps only bit 3, which is the interrupt enable; its other bits read zero.
- R2: Status bit 0 is complete, bit 1 is fail, bit 2 is busy and bit 3 is interrupt pending. Bit 5 is the burst flag and always reads zero. Bit 4 and bits 15..6 read zero.
- R3: Writing a command code when the controller is idle starts an operation: 0x01 read, 0x02 write, 0x03 erase-then-write, 0x04 verify, 0x05 page erase. Busy then reads one for exactly the cycles set for that code: T_READ for read and verify, T_WRITE, T_ERASE_WRITE and T_ERASE. Code 0x00 and codes 0x06 to 0xFF start nothing.
- R4: At the end of every operation, busy clears and complete sets. A status read clears complete, fail and interrupt pending. If a completion and a status read fall in the same cycle, the completion wins.
- R5: Interrupt pending sets at completion only when mode bit 3 is one. `irq` follows it, and a status read drops it.
- R6: A read command loads the data register with the word at the low ADDR_W bits of the address register.
- R7: A write command stores the old word ANDed with the data word.
- R8: A page erase sets every word of the page holding the address to 0xFFFF and leaves other pages unchanged. A page is PAGE_WORDS words aligned to its size.
- R9: Erase-then-write erases the addressed page and then leaves the data word itself at the address.
- R10: Verify sets fail when the addressed word differs from the data register and leaves both unchanged.
- R11: A valid command written while busy is ignored. The running operation keeps its timing and its address and data as latched at its start. Fail is set when the running operation ends.
- R12: After reset every array word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears sticky status when the status register is selected) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt, follows interrupt pending |

## Verification
The hardest case to reach from the ports is a status read that lands in the very cycle an operation completes. The bench gets there by polling the status register on every cycle while a command runs. One poll therefore always coincides with the completion edge, and the final poll must still show complete set. The same back-to-back polling counts busy cycles exactly for each command code.

A command written in the middle of a long erase exercises the ignore-and-fail path. The address register is changed before that second command, so the bench can also show that the erase used the address latched when it started.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [7:0] {
        CMD_NULL        = 8'h00,
        CMD_READ        = 8'h01,
        CMD_WRITE       = 8'h02,
        CMD_ERASE_WRITE = 8'h03,
        CMD_VERIFY      = 8'h04,
        CMD_ERASE       = 8'h05
    } cmd_e;

    localparam logic [2:0] RA_STATUS = 3'd0;
    localparam logic [2:0] RA_MODE   = 3'd1;
    localparam logic [2:0] RA_CMD    = 3'd2;
    localparam logic [2:0] RA_DATA   = 3'd3;
    localparam logic [2:0] RA_ADDR   = 3'd4;

    localparam int MODE_IE_BIT = 3;

endpackage

// File: rtl/fcc_timer.sv
module fcc_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] dur,
    output logic             running,
    output logic             done
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.run && (tmr_q.cnt == '0);
        if (done) begin
            tmr_d.run = 1'b0;
        end
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = dur - CNT_W'(1);
        end else if (tmr_q.run && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign running = tmr_q.run;

    // R3: an operation is only started from idle and never with zero length
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!tmr_q.run && dur != '0));

    // R4: completion is a single-cycle event that ends the run
    p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !running));

endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        logic [ADDR_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < WORDS; i++) begin
            idx      = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (erase_en && idx[ADDR_W-1:PAGE_W] == addr[ADDR_W-1:PAGE_W]) begin
                mem_d[i] = '1;
            end
            if (wr_en && idx == addr) begin
                mem_d[i] = (erase_en ? {DATA_W{1'b1}} : mem_q[i]) & wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[addr];

    // R8: a plain erase leaves the addressed word all ones
    p_erase_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && !wr_en) |=> (mem_q[$past(addr)] == {DATA_W{1'b1}}));

    // R7: a plain write can only clear bits of the old word
    p_and_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase_en) |=> (mem_q[$past(addr)] == ($past(rdata) & $past(wdata))));

    // R9: erase-then-write leaves exactly the new word
    p_erase_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && erase_en) |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W        = 10,
    parameter int PAGE_WORDS    = 256,
    parameter int T_READ        = 2,
    parameter int T_WRITE       = 20,
    parameter int T_ERASE       = 20000,
    parameter int T_ERASE_WRITE = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);

    localparam int PAGE_W = $clog2(PAGE_WORDS);
    localparam int T_MAX1 = (T_READ > T_WRITE) ? T_READ : T_WRITE;
    localparam int T_MAX2 = (T_ERASE > T_ERASE_WRITE) ? T_ERASE : T_ERASE_WRITE;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    typedef struct packed {
        logic              ie;
        logic [7:0]        cmd;
        logic [15:0]       data;
        logic [15:0]       addr;
        logic              done;
        logic              fail;
        logic              irqp;
        logic              overrun;
        cmd_e              op;
        logic [15:0]       op_data;
        logic [ADDR_W-1:0] op_addr;
    } st_t;

    st_t st_d, st_q;

    logic             busy;
    logic             t_done;
    logic             t_start;
    logic [CNT_W-1:0] t_dur;
    logic             arr_wr;
    logic             arr_erase;
    logic [15:0]      arr_rdata;
    logic             cmd_wr;
    logic             code_ok;
    logic             stat_rd;
    logic             overrun_now;

    assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
    assign code_ok = (reg_wdata[7:0] >= 8'h01) && (reg_wdata[7:0] <= 8'h05);
    assign stat_rd = reg_rd && (reg_addr == RA_STATUS);

    always_comb begin
        st_d        = st_q;
        t_start     = 1'b0;
        t_dur       = '0;
        arr_wr      = 1'b0;
        arr_erase   = 1'b0;
        overrun_now = st_q.overrun || (cmd_wr && code_ok && busy);

        if (reg_wr) begin
            unique case (reg_addr)
                RA_MODE: st_d.ie   = reg_wdata[MODE_IE_BIT];
                RA_DATA: st_d.data = reg_wdata;
                RA_ADDR: st_d.addr = reg_wdata;
                RA_CMD:  st_d.cmd  = reg_wdata[7:0];
                default: ;
            endcase
        end

        if (cmd_wr && code_ok) begin
            if (busy) begin
                st_d.overrun = 1'b1;
            end else begin
                t_start      = 1'b1;
                st_d.op      = cmd_e'(reg_wdata[7:0]);
                st_d.op_addr = st_q.addr[ADDR_W-1:0];
                st_d.op_data = st_q.data;
                unique case (reg_wdata[2:0])
                    3'd2:    t_dur = CNT_W'(T_WRITE);
                    3'd3:    t_dur = CNT_W'(T_ERASE_WRITE);
                    3'd5:    t_dur = CNT_W'(T_ERASE);
                    default: t_dur = CNT_W'(T_READ);
                endcase
            end
        end

        if (stat_rd) begin
            st_d.done = 1'b0;
            st_d.fail = 1'b0;
            st_d.irqp = 1'b0;
        end

        if (t_done) begin
            st_d.done    = 1'b1;
            st_d.overrun = 1'b0;
            if (st_q.ie) begin
                st_d.irqp = 1'b1;
            end
            if (overrun_now || (st_q.op == CMD_VERIFY && arr_rdata != st_q.op_data)) begin
                st_d.fail = 1'b1;
            end
            unique case (st_q.op)
                CMD_READ:        st_d.data = arr_rdata;
                CMD_WRITE:       arr_wr = 1'b1;
                CMD_ERASE_WRITE: begin
                    arr_wr    = 1'b1;
                    arr_erase = 1'b1;
                end
                CMD_ERASE:       arr_erase = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_STATUS: reg_rdata = {10'b0, 1'b0, 1'b0, st_q.irqp, busy, st_q.fail, st_q.done};
            RA_MODE:   reg_rdata = {12'b0, st_q.ie, 3'b0};
            RA_CMD:    reg_rdata = {8'b0, st_q.cmd};
            RA_DATA:   reg_rdata = st_q.data;
            RA_ADDR:   reg_rdata = st_q.addr;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = st_q.irqp;

    fcc_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .dur     (t_dur),
        .running (busy),
        .done    (t_done)
    );

    fcc_array #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W),
        .DATA_W(16)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (arr_wr),
        .erase_en (arr_erase),
        .addr     (st_q.op_addr),
        .wdata    (st_q.op_data),
        .rdata    (arr_rdata)
    );

    // R3: a valid code written while idle makes the controller busy
    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && code_ok && !busy) |=> busy);

    // R3: null and undefined codes leave an idle controller idle
    p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !code_ok && !busy) |=> !busy);

    // R4: completion wins over a same-cycle status read
    p_end_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |=> (st_q.done && !busy));

    // R4: a status read clears the sticky bits when no completion coincides
    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !t_done) |=> (!st_q.done && !st_q.fail && !irq));

    // R5: the interrupt only rises at a completion with the enable set
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(t_done && st_q.ie));

    // R2: reserved and burst status bits stay zero
    p_status_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_STATUS) |-> (reg_rdata[15:4] == 12'h000));

    // R11: a command that arrived while busy turns into a failure
    p_overrun_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (t_done && st_q.overrun) |=> st_q.fail);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

    localparam int ADDR_W  = 6;
    localparam int PWORDS  = 16;
    localparam int WORDS   = 1 << ADDR_W;
    localparam int TR      = 2;
    localparam int TW      = 4;
    localparam int TE      = 300;
    localparam int TEW     = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int          n_chk = 0;
    int          n_err = 0;
    logic        irq_seen;
    logic [15:0] mdl [WORDS];

    always #10 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_WORDS(PWORDS), .T_READ(TR),
        .T_WRITE(TW), .T_ERASE(TE), .T_ERASE_WRITE(TEW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // each access task spans exactly one clock, from negedge to negedge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        irq_seen = irq;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic run(input logic [7:0] code, output logic [15:0] st, output int nbusy);
        logic [15:0] s;
        wr(3'd2, {8'h00, code});
        nbusy = 0;
        s = 16'h0;
        for (int k = 0; k < 1000; k++) begin
            rd(3'd0, s);
            if (!s[2]) break;
            nbusy++;
        end
        st = s;
    endtask

    task automatic read_word(input int a, output logic [15:0] d);
        logic [15:0] st;
        int nb;
        wr(3'd4, 16'(a));
        run(8'h01, st, nb);
        rd(3'd3, d);
    endtask

    task automatic compare_all(input string req);
        logic [15:0] d;
        for (int a = 0; a < WORDS; a++) begin
            read_word(a, d);
            chk(req, {16'h0, d}, {16'h0, mdl[a]});
        end
    endtask

    function automatic logic [15:0] pat1(input int a);
        logic [15:0] v;
        v = 16'(a);
        return (v * 16'h0505) ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] pat2(input int a);
        logic [15:0] v;
        v = 16'(a);
        return ~(v * 16'h0111);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R3 watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] st;
        int nb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every register and the interrupt
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
        for (int r = 0; r < 5; r++) begin
            rd(3'(r), d);
            chk("R1 reset register", {16'(r), d}, {16'(r), 16'h0000});
        end

        for (int a = 0; a < WORDS; a++) mdl[a] = 16'hFFFF;

        // R12 and R6: erased array after reset, read path sweep
        compare_all("R12 R6 reset array");

        // R3/R4/R2: read command timing and status content
        wr(3'd4, 16'h0007);
        run(8'h01, st, nb);
        chk("R3 read busy cycles", nb, TR);
        chk("R4 R2 read status", {16'h0, st}, 32'h0001);

        // R7: write sweep, first pattern then AND with second
        for (int a = 0; a < WORDS; a++) begin
            wr(3'd4, 16'(a));
            wr(3'd3, pat1(a));
            run(8'h02, st, nb);
            if (a == 0) begin
                chk("R3 write busy cycles", nb, TW);
                chk("R4 write status", {16'h0, st}, 32'h0001);
            end
            mdl[a] = mdl[a] & pat1(a);
        end
        compare_all("R7 first write");
        for (int a = 0; a < WORDS; a++) begin
            wr(3'd4, 16'(a));
            wr(3'd3, pat2(a));
            run(8'h02, st, nb);
            mdl[a] = mdl[a] & pat2(a);
        end
        compare_all("R7 AND write");

        // R10: verify match and mismatch
        for (int a = 0; a < WORDS; a += 5) begin
            wr(3'd4, 16'(a));
            wr(3'd3, mdl[a]);
            run(8'h04, st, nb);
            chk("R10 verify match", {16'h0, st}, 32'h0001);
            wr(3'd3, mdl[a] ^ (16'h1 << (a % 16)));
            run(8'h04, st, nb);
            if (a == 0) chk("R3 verify busy cycles", nb, TR);
            chk("R10 verify mismatch", {16'h0, st}, 32'h0003);
            rd(3'd3, d);
            chk("R10 data unchanged", {16'h0, d}, {16'h0, mdl[a] ^ (16'h1 << (a % 16))});
        end

        // R8: page erase of page 1
        wr(3'd4, 16'd19);
        run(8'h05, st, nb);
        chk("R3 erase busy cycles", nb, TE);
        chk("R8 erase status", {16'h0, st}, 32'h0001);
        for (int a = 16; a < 32; a++) mdl[a] = 16'hFFFF;
        compare_all("R8 page erase");

        // R9: erase-then-write inside page 2
        wr(3'd4, 16'd37);
        wr(3'd3, 16'h1234);
        run(8'h03, st, nb);
        chk("R3 erase-write busy cycles", nb, TEW);
        for (int a = 32; a < 48; a++) mdl[a] = 16'hFFFF;
        mdl[37] = 16'h1234;
        compare_all("R9 erase-write");

        // R5 and R1: interrupt enable and mode reserved bits
        wr(3'd1, 16'hFFFF);
        rd(3'd1, d);
        chk("R1 mode reserved bits", {16'h0, d}, 32'h0008);
        wr(3'd4, 16'd2);
        run(8'h01, st, nb);
        chk("R5 irq at completion", {31'h0, irq_seen}, 32'h1);
        chk("R5 R2 pending bit", {16'h0, st}, 32'h0009);
        chk("R5 irq cleared by read", {31'h0, irq}, 32'h0);
        rd(3'd0, d);
        chk("R4 sticky cleared", {16'h0, d}, 32'h0000);
        wr(3'd1, 16'h0000);
        run(8'h01, st, nb);
        chk("R5 irq disabled", {31'h0, irq_seen}, 32'h0);
        chk("R5 no pending bit", {16'h0, st}, 32'h0001);

        // R3: null and undefined codes do nothing
        for (int c = 0; c < 256; c += 6) begin
            if (c >= 1 && c <= 5) continue;
            wr(3'd2, 16'(c));
            rd(3'd0, d);
            chk("R3 ignored code", {16'(c), d}, {16'(c), 16'h0000});
        end

        // R11: command during an erase is ignored and flagged
        wr(3'd4, 16'd10);
        run(8'h00, st, nb);
        wr(3'd2, 16'h0005);
        rd(3'd0, d);
        chk("R11 busy during erase", {16'h0, d}, 32'h0004);
        wr(3'd4, 16'd50);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'h0002);
        nb = 4;
        for (int k = 0; k < 1000; k++) begin
            rd(3'd0, d);
            if (!d[2]) break;
            nb++;
        end
        chk("R11 timing kept", nb, TE);
        chk("R11 fail at end", {16'h0, d}, 32'h0003);
        for (int a = 0; a < 16; a++) mdl[a] = 16'hFFFF;
        compare_all("R11 latched erase and ignored write");

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule